// File: doc/BRIEF.md
# Two-Channel Soft-Ramped PCM Volume and Mute

This block scales two streams of signed 24-bit PCM samples by a gain set in half-decibel steps. Each channel has its own 8-bit attenuation code, and a master code is added to both. The resulting code picks a linear multiplier made from a twelve-entry mantissa table (one 6 dB octave) and a binary shift. Every accepted sample is rounded and clamped to 24 bits, and the result appears on the output one clock later.

The gain in use does not jump when the code changes. A per-channel applied code moves toward the requested code by one half-decibel step after a programmable number of samples. A soft mute makes silence the target, so the gain fades out. A hard mute zeroes the samples straight away. A per-channel zero detector raises a flag once a long run of all-zero input has been seen.

The block sits between a serial audio receiver and the downstream modulator. Its gain and mute controls are driven from configuration registers elsewhere in the chip.

Top module: `pcm_softvol`

## Requirements
- R1: After reset, `out_valid` is low, both outputs are zero and both `zero_muted` bits are low. The applied code of each channel starts at 255 (silence), so early samples come out as zero until the gain ramps.
- R2: Each sample accepted with `smp_valid` high gives one result, with `out_valid` high, on the next clock. For an applied code c below 255, let q = c/12 and r = c%12. Let T[r] = round(32768·2^(-r/12)). The result is (x·T[r] + 2^(s-1)) >> s with an arithmetic shift and s = 7+q, so code 0 is +48 dB and each code step is -0.5 dB.
- R3: The requested code is the channel code plus the master code, clamped at 255. Code 255 always gives a zero output.
- R4: Let N = `ramp_len`, with 0 read as 1. Per channel, every accepted sample that finds the applied code different from the requested code advances a counter. When the counter reaches N, the applied code moves one step toward the requested code and the counter clears. A sample is scaled with the applied code held before that sample's step. The counter clears whenever the applied code equals the requested code.
- R5: A channel soft mute bit, or the master soft mute, makes 255 the requested code, so the gain ramps down at the R4 rate. Releasing it ramps the gain back up the same way.
- R6: A channel hard mute bit, or the master hard mute, zeroes the result of every sample accepted while it is high. The applied code keeps ramping as in R4.
- R7: `zero_muted[i]` rises in the cycle after the 2048th consecutive accepted all-zero sample on channel i. It falls after the first accepted nonzero sample on that channel. The two channels are independent.
- R8: Results beyond the 24-bit signed range are clamped to +8388607 or -8388608.
- R9: Gain codes, soft mutes and hard mutes act on each channel separately.
- R10: While `smp_valid` is low, `out_valid` is low, the output samples hold their values and the applied codes do not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_ch0 | input | 24 | Channel 0 input sample, signed |
| smp_ch1 | input | 24 | Channel 1 input sample, signed |
| gain_ch0 | input | 8 | Channel 0 attenuation code |
| gain_ch1 | input | 8 | Channel 1 attenuation code |
| gain_mst | input | 8 | Master attenuation code |
| ramp_len | input | 8 | Samples per ramp step (0 read as 1) |
| soft_mute | input | 2 | Per-channel soft mute |
| hard_mute | input | 2 | Per-channel hard mute |
| soft_mute_mst | input | 1 | Master soft mute |
| hard_mute_mst | input | 1 | Master hard mute |
| out_valid | output | 1 | Result strobe |
| out_ch0 | output | 24 | Channel 0 scaled sample, signed |
| out_ch1 | output | 24 | Channel 1 scaled sample, signed |
| zero_muted | output | 2 | Per-channel zero-run flag |

## Verification
The assertions assume reset is asserted at the start of time. They also assume `smp_valid` is a clean one-bit strobe, and that any gain, ramp or mute control may change only between accepted samples. Under those conditions, the applied code can move at most one step per sample and must not move on idle cycles. The bench meets these assumptions by changing every control and sample on the falling clock edge, keeping the strobe low through reset, and holding controls steady while each settling ramp runs.

// File: rtl/softvol_pkg.sv
package softvol_pkg;
  localparam int DATA_W    = 24;
  localparam int CODE_W    = 8;
  localparam int NCH       = 2;
  localparam int ZERO_RUN  = 2048;

  // Sum of two attenuation codes, clamped to the silence code.
  function automatic logic [CODE_W-1:0] add_codes(input logic [CODE_W-1:0] a,
                                                  input logic [CODE_W-1:0] b);
    logic [CODE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CODE_W] ? {CODE_W{1'b1}} : s[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/softvol_ramp.sv
module softvol_ramp #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] chan_code,
  input  logic [CODE_W-1:0] mst_code,
  input  logic              soft_mute,
  input  logic [CNT_W-1:0]  ramp_len,
  output logic [CODE_W-1:0] applied_code
);
  import softvol_pkg::*;

  localparam logic [CODE_W-1:0] SIL = {CODE_W{1'b1}};

  logic [CODE_W-1:0] target;
  logic [CODE_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    cnt_inc, n_eff;

  always_comb begin
    target  = soft_mute ? SIL : add_codes(chan_code, mst_code);
    n_eff   = (ramp_len == '0) ? (CNT_W+1)'(1) : {1'b0, ramp_len};
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    if (smp_valid) begin
      if (cur_q == target) begin
        cnt_d = '0;
      end else if (cnt_inc >= n_eff) begin
        cur_d = (cur_q < target) ? cur_q + 1'b1 : cur_q - 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= SIL;
      cnt_q <= '0;
    end else if (smp_valid) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign applied_code = cur_q;

  // R4: at most one step per accepted sample
  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + 1'b1)
                  || ($past(cur_q) == cur_q + 1'b1));

  // R10: no stepping without a sample
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cur_q));
endmodule

// File: rtl/softvol_zero_det.sv
module softvol_zero_det #(
  parameter int DATA_W = 24,
  parameter int RUN    = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp,
  output logic              muted
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);

  logic [CW-1:0] run_q, run_d;
  logic          is_zero;

  always_comb begin
    is_zero = (smp == '0);
    run_d   = run_q;
    if (smp_valid) begin
      if (!is_zero)           run_d = '0;
      else if (run_q != RUN_C) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (smp_valid) run_q <= run_d;
  end

  assign muted = (run_q == RUN_C);

  // R7: flag rises only after an accepted zero sample
  p_rise_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(smp_valid && is_zero));

  // R7: flag falls only after an accepted nonzero sample
  p_fall_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> $past(smp_valid && !is_zero));
endmodule

// File: rtl/softvol_scale.sv
module softvol_scale #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [CODE_W-1:0]        code,
  input  logic                     force_zero,
  input  logic signed [DATA_W-1:0] smp,
  output logic signed [DATA_W-1:0] result
);
  localparam int STEPS      = 12;  // half-dB steps per octave
  localparam int FRAC_W     = 15;  // mantissa fraction bits
  localparam int TAB_W      = FRAC_W + 1;
  localparam int BOOST_OCT  = 8;   // +48 dB headroom in octaves
  localparam int SHIFT_BASE = FRAC_W - BOOST_OCT;
  localparam int PROD_W     = DATA_W + TAB_W + 1;
  localparam int SUM_W      = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - 1;

  function automatic logic [TAB_W-1:0] mant(input logic [3:0] idx);
    case (idx)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30929;
      4'd2:    return 16'd29193;
      4'd3:    return 16'd27554;
      4'd4:    return 16'd26008;
      4'd5:    return 16'd24548;
      4'd6:    return 16'd23170;
      4'd7:    return 16'd21870;
      4'd8:    return 16'd20643;
      4'd9:    return 16'd19484;
      4'd10:   return 16'd18390;
      default: return 16'd17358;
    endcase
  endfunction

  logic [4:0]                oct;
  logic [3:0]                rem;
  logic [5:0]                shamt;
  logic signed [PROD_W-1:0]  prod;
  logic signed [SUM_W-1:0]   rnd, shifted;
  logic signed [DATA_W-1:0]  clamped, res_d;

  always_comb begin
    oct     = 5'(code / CODE_W'(STEPS));
    rem     = 4'(code % CODE_W'(STEPS));
    shamt   = 6'(SHIFT_BASE) + {1'b0, oct};
    prod    = $signed({{(PROD_W-DATA_W){smp[DATA_W-1]}}, smp})
            * $signed({{(PROD_W-TAB_W){1'b0}}, mant(rem)});
    rnd     = {prod[PROD_W-1], prod} + (SUM_W'(1) << (shamt - 6'd1));
    shifted = rnd >>> shamt;
    if (shifted > MAXV)      clamped = MAXV[DATA_W-1:0];
    else if (shifted < MINV) clamped = MINV[DATA_W-1:0];
    else                     clamped = shifted[DATA_W-1:0];
    res_d   = ((&code) || force_zero) ? '0 : clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (smp_valid) result <= res_d;
  end

  // R3: the silence code yields a zero result
  p_silence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (&code)) |=> (result == '0));
endmodule

// File: rtl/pcm_softvol.sv
module pcm_softvol #(
  parameter int DATA_W   = softvol_pkg::DATA_W,
  parameter int CODE_W   = softvol_pkg::CODE_W,
  parameter int ZERO_RUN = softvol_pkg::ZERO_RUN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_ch0,
  input  logic signed [DATA_W-1:0] smp_ch1,
  input  logic [CODE_W-1:0]        gain_ch0,
  input  logic [CODE_W-1:0]        gain_ch1,
  input  logic [CODE_W-1:0]        gain_mst,
  input  logic [CODE_W-1:0]        ramp_len,
  input  logic [1:0]               soft_mute,
  input  logic [1:0]               hard_mute,
  input  logic                     soft_mute_mst,
  input  logic                     hard_mute_mst,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_ch0,
  output logic signed [DATA_W-1:0] out_ch1,
  output logic [1:0]               zero_muted
);
  localparam int NCH = softvol_pkg::NCH;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic signed [DATA_W-1:0] smp_a  [NCH];
  logic signed [DATA_W-1:0] res_a  [NCH];
  logic [CODE_W-1:0]        gain_a [NCH];
  logic [CODE_W-1:0]        code_a [NCH];
  logic [NCH-1:0]           hard_eff;

  assign smp_a[0]  = smp_ch0;
  assign smp_a[1]  = smp_ch1;
  assign gain_a[0] = gain_ch0;
  assign gain_a[1] = gain_ch1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hard_eff[i] = hard_mute[i] | hard_mute_mst;

    softvol_ramp #(.CODE_W(CODE_W), .CNT_W(CODE_W)) u_ramp (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .smp_valid    (smp_valid),
      .chan_code    (gain_a[i]),
      .mst_code     (gain_mst),
      .soft_mute    (soft_mute[i] | soft_mute_mst),
      .ramp_len     (ramp_len),
      .applied_code (code_a[i])
    );

    softvol_scale #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_scale (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .smp_valid  (smp_valid),
      .code       (code_a[i]),
      .force_zero (hard_eff[i]),
      .smp        (smp_a[i]),
      .result     (res_a[i])
    );

    softvol_zero_det #(.DATA_W(DATA_W), .RUN(ZERO_RUN)) u_zdet (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .smp_valid (smp_valid),
      .smp       (smp_a[i]),
      .muted     (zero_muted[i])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_valid <= 1'b0;
    else            out_valid <= smp_valid;
  end

  assign out_ch0 = res_a[0];
  assign out_ch1 = res_a[1];

  // R2: one result per accepted sample, one clock later
  p_result_strobe_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    smp_valid |=> out_valid);

  // R10: idle cycles produce no result and hold outputs
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !smp_valid |=> (!out_valid && $stable(out_ch0) && $stable(out_ch1)));

  // R6: hard mute zeroes the sample taken under it
  p_hard_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (smp_valid && hard_eff[0]) |=> (out_ch0 == '0));
endmodule

// File: tb/pcm_softvol_bench.sv
module pcm_softvol_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, smp_valid, soft_mute_mst, hard_mute_mst, out_valid;
  logic signed [23:0] smp_ch0, smp_ch1, out_ch0, out_ch1;
  logic [7:0] gain_ch0, gain_ch1, gain_mst, ramp_len;
  logic [1:0] soft_mute, hard_mute, zero_muted;

  pcm_softvol u_pcm_softvol (.*);

  typedef struct { logic signed [23:0] e0, e1; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0;
  int cur[2], cnt[2];
  bit done = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tgt(int ch);
    int g, s;
    g = (ch == 0) ? gain_ch0 : gain_ch1;
    s = g + gain_mst;
    if (s > 255) s = 255;
    if (soft_mute[ch] || soft_mute_mst) s = 255;
    return s;
  endfunction

  function automatic logic signed [23:0] expect_out(logic signed [23:0] x, int code);
    int q, r, s;
    longint t, y;
    if (code == 255) return 24'sd0;
    q = code / 12; r = code % 12; s = 7 + q;
    t = longint'($rtoi(32768.0 * (2.0 ** (-r / 12.0)) + 0.5));
    y = (longint'(x) * t + (longint'(1) <<< (s - 1))) >>> s;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    return 24'(y);
  endfunction

  // Driver: computes the expected result, steps the model, drives one sample
  task automatic send(logic signed [23:0] x0, logic signed [23:0] x1, string tag);
    item_t it;
    int n;
    logic signed [23:0] xs[2];
    xs[0] = x0; xs[1] = x1;
    n = (ramp_len == 0) ? 1 : ramp_len;
    for (int c = 0; c < 2; c++) begin
      logic signed [23:0] e;
      int t;
      e = (hard_mute[c] || hard_mute_mst) ? 24'sd0 : expect_out(xs[c], cur[c]);
      if (c == 0) it.e0 = e; else it.e1 = e;
      t = tgt(c);
      if (cur[c] == t) cnt[c] = 0;
      else if (cnt[c] + 1 >= n) begin
        cur[c] = (cur[c] < t) ? cur[c] + 1 : cur[c] - 1;
        cnt[c] = 0;
      end else cnt[c]++;
    end
    it.tag = tag;
    sbq.push_back(it);
    smp_ch0 = x0; smp_ch1 = x1; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic signed [23:0] rnd_smp();
    return 24'($urandom()) | 24'sd1;
  endfunction

  task automatic settle(string tag);
    for (int k = 0; k < 800; k++) begin
      if (cur[0] == tgt(0) && cur[1] == tgt(1)) break;
      send(rnd_smp(), rnd_smp(), tag);
    end
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected result actual=1 expected=0");
      end else begin
        item_t it;
        it = sbq.pop_front();
        check({it.tag, " ch0"}, out_ch0, it.e0);
        check({it.tag, " ch1"}, out_ch1, it.e1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [23:0] h0, h1;
    rst_n = 0; smp_valid = 0; smp_ch0 = 0; smp_ch1 = 0;
    gain_ch0 = 0; gain_ch1 = 0; gain_mst = 0; ramp_len = 1;
    soft_mute = 0; hard_mute = 0; soft_mute_mst = 0; hard_mute_mst = 0;
    cur[0] = 255; cur[1] = 255; cnt[0] = 0; cnt[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 out_ch0", out_ch0, 0);
    check("R1 out_ch1", out_ch1, 0);
    check("R1 zero_muted", zero_muted, 0);
    send(24'sd100000, -24'sd100000, "R1 silent start");
    send(24'sd5, 24'sd7, "R1 silent start");

    // R4: ramp one step per sample down to +48 dB
    settle("R4 ramp_len=1");
    send(24'sd1000, -24'sd1000, "R2 code0");
    send(24'sd1, -24'sd1, "R2 code0 small");
    // R8: clamp at the 24-bit limits
    send(24'sh7FFFFF, -24'sh800000, "R8 clamp");
    send(24'sd40000, -24'sd40000, "R8 clamp edge");

    // R2/R9: distinct channel codes with master added, slower ramp
    gain_ch0 = 24; gain_ch1 = 7; gain_mst = 4; ramp_len = 3;
    settle("R4 ramp_len=3");
    for (int k = 0; k < 6; k++) send(rnd_smp(), rnd_smp(), "R9 per-channel gain");
    send(-24'sd1, 24'sd3, "R2 rounding");

    // R4: ramp_len 0 behaves as 1
    ramp_len = 0; gain_ch0 = 61;
    settle("R4 ramp_len=0");
    send(24'sd8388607, -24'sd8388607, "R2 deep code");

    // R3: sum clamps at 255 and gives silence
    ramp_len = 1; gain_ch0 = 200; gain_mst = 100;
    settle("R3 clamp ramp");
    send(24'sd8388607, 24'sd8388607, "R3 silence");
    gain_ch0 = 30; gain_mst = 0;
    settle("R3 recover");

    // R5: soft mute of one channel, then master, then release
    soft_mute = 2'b10;
    settle("R5 soft ch1");
    send(24'sd300000, 24'sd300000, "R5 ch1 silent R9");
    soft_mute = 2'b00; soft_mute_mst = 1; ramp_len = 2;
    settle("R5 soft master");
    soft_mute_mst = 0;
    settle("R5 release");

    // R6: hard mute acts on the same sample, ramp continues
    hard_mute = 2'b01;
    send(24'sd200000, 24'sd200000, "R6 hard ch0");
    hard_mute = 2'b00; hard_mute_mst = 1; gain_ch1 = 20;
    for (int k = 0; k < 4; k++) send(rnd_smp(), rnd_smp(), "R6 hard master");
    hard_mute_mst = 0;
    for (int k = 0; k < 4; k++) send(rnd_smp(), rnd_smp(), "R6 ramp kept");

    // R10: idle cycles
    @(negedge clk);
    h0 = out_ch0; h1 = out_ch1;
    for (int k = 0; k < 5; k++) begin
      smp_ch0 = rnd_smp(); smp_ch1 = rnd_smp(); gain_ch0 = 8'(k * 9);
      @(negedge clk);
      check("R10 out_valid idle", out_valid, 0);
      check("R10 ch0 held", out_ch0, h0);
      check("R10 ch1 held", out_ch1, h1);
    end
    gain_ch0 = 30;
    send(24'sd12345, 24'sd12345, "R10 no step while idle");

    // R7: zero-run flag on channel 0 only
    for (int k = 0; k < 2047; k++) send(24'sd0, rnd_smp(), "R7 zero run");
    check("R7 flag before run ends", zero_muted, 2'b00);
    send(24'sd0, rnd_smp(), "R7 zero run");
    check("R7 flag after 2048 zeros", zero_muted, 2'b01);
    send(24'sd0, rnd_smp(), "R7 zero run");
    check("R7 flag held", zero_muted, 2'b01);
    send(24'sd9, rnd_smp(), "R7 release");
    check("R7 flag released", zero_muted, 2'b00);

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule